// File: doc/BRIEF.md
# Accumulator CPU Execution Core

This block is the sequencer and datapath of a small 8-bit accumulator machine with a 16-bit address space. It owns a single byte-wide synchronous memory port: an address, write data, a write strobe, and read data that comes back one cycle after the address is presented. Each instruction is one, two or three bytes long. The core fetches the opcode, then the operand bytes the opcode calls for, then any data byte or pointer bytes the operation needs. After that it executes.

Opcodes that take a small address carry it in their low nibble. A zero low nibble selects a following full operand byte instead. The operations are:
- ALU work against the accumulator, with a zero flag.
- Direct and pointer-based stores.
- Short and long jumps, including branches on the zero flag.
- Subroutine call and return through a downward-growing 8-bit stack.
- Halt.

The program counter, accumulator, stack pointer, zero flag and a halted status are visible as outputs.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted, the outputs read as follows: PC 0x0000, SP 0xFF, ACC 0x00, zero flag 0, halted 0.
- R2: An instruction that does not transfer control leaves PC at its own address plus its length: 1, 2 or 3.
- R3: For the classes 0x1_ LDA, 0x3_ ADD, 0x4_ SUB, 0x5_ AND, 0x6_ OR, 0x7_ XOR, 0x8_ JZ, 0x9_ JNZ, 0xB_ JMP, 0xC_ CALL, 0xE_ DIV and 0x2_ STA, the operand is chosen by the low nibble. A nonzero low nibble is the operand, and the instruction is 1 byte. A zero low nibble means the next byte is the operand, and the instruction is 2 bytes. Class 0x2 is the exception: 0x21 takes a byte operand and 0x20 is the indirect store.
- R4: Each of these operations writes its 8-bit result, modulo 256, to ACC: LDA (memory), LDI 0xA0 (immediate), ADD, SUB (ACC minus memory), AND, OR, XOR, MUL 0xF1 (low 8 bits of the product) and NOT 0xF2.
- R5: DIV writes the truncated quotient ACC/memory. When the divisor is zero it writes 0xFF.
- R6: The zero flag becomes 1 exactly when the value written to ACC is zero. CMP 0xF3 sets the flag from ACC minus memory and leaves ACC unchanged.
- R7: A direct store writes ACC once to address {0x00, operand}. Memory writes happen only in the execute step.
- R8: The indirect store 0x20 HH LL writes ACC once to address {mem[HH], mem[LL]}.
- R9: Short jumps JMP and JZ/JNZ use a target zero-extended from 8 bits. JZ is taken when the flag is 1 and JNZ when it is 0. A branch that is not taken advances by its length.
- R10: Long jumps 0xF8 (JZ), 0xF9 (JMP) and 0xFA (JNZ) carry the high address byte second and the low byte third, and load the full 16-bit target.
- R11: CALL decrements SP, writes the low byte of its return address to mem[SP], and jumps to the zero-extended target. RET 0xD0 loads PC with {0x00, mem[SP]} and then increments SP.
- R12: After HLT 0xF0, halted stays 1 and PC keeps the address of the HLT instruction. No further memory write occurs until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after its address |
| pc_o | output | 16 | Program counter |
| acc_o | output | 8 | Accumulator |
| sp_o | output | 8 | Stack pointer |
| zf_o | output | 1 | Zero flag |
| halted_o | output | 1 | Halted status |

## Verification
Three programs drive the core.

The first is an arithmetic chain. It stores intermediate results, which separates every ALU kind: a mis-coded operation shows up as a wrong stored byte rather than only as a wrong final value. It also covers a zero divisor and a compare whose equal operands must not disturb a nonzero ACC.

The second is a countdown loop that uses nibble-operand branches. It takes each conditional branch both ways, which tells a wrong flag polarity apart from a wrong target.

The third mixes a call and return, a pointer-based store and long jumps taken and not taken. It distinguishes high/low byte order errors and stack ordering errors through the stored addresses.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam int DW = 8;
  localparam int AW = 16;
  localparam int LW = 2;

  typedef enum logic [3:0] {
    ST_FETCH, ST_OPC, ST_OPND1, ST_OPND2, ST_DISP,
    ST_PTRHI, ST_PTRLO, ST_MEMRD, ST_EXEC, ST_HALT
  } state_e;

  typedef enum logic [4:0] {
    K_NOP, K_LDA, K_STA, K_STI, K_ADD, K_SUB, K_AND, K_OR, K_XOR,
    K_JZ, K_JNZ, K_JMP, K_CALL, K_RET, K_DIV, K_LDI, K_MUL, K_CMP,
    K_HLT, K_NOT, K_JZL, K_JMPL, K_JNZL
  } kind_e;

  typedef struct packed {
    kind_e         kind;
    logic [LW-1:0] len;
    logic          rd_mem;
  } dec_t;

  // opcode byte -> operation kind, byte length, needs a data read
  function automatic dec_t decode_op(input logic [DW-1:0] op);
    dec_t          d;
    logic [LW-1:0] nib_len;
    nib_len  = (op[3:0] == 4'h0) ? 2'd2 : 2'd1;
    d.kind   = K_NOP;
    d.len    = 2'd1;
    d.rd_mem = 1'b0;
    case (op[7:4])
      4'h1: begin d.kind = K_LDA;  d.len = nib_len; end
      4'h2: begin
        if (op[3:0] == 4'h0)      begin d.kind = K_STI; d.len = 2'd3; end
        else if (op[3:0] == 4'h1) begin d.kind = K_STA; d.len = 2'd2; end
        else                      begin d.kind = K_STA; d.len = 2'd1; end
      end
      4'h3: begin d.kind = K_ADD;  d.len = nib_len; end
      4'h4: begin d.kind = K_SUB;  d.len = nib_len; end
      4'h5: begin d.kind = K_AND;  d.len = nib_len; end
      4'h6: begin d.kind = K_OR;   d.len = nib_len; end
      4'h7: begin d.kind = K_XOR;  d.len = nib_len; end
      4'h8: begin d.kind = K_JZ;   d.len = nib_len; end
      4'h9: begin d.kind = K_JNZ;  d.len = nib_len; end
      4'hA: if (op[3:0] == 4'h0) begin d.kind = K_LDI; d.len = 2'd2; end
      4'hB: begin d.kind = K_JMP;  d.len = nib_len; end
      4'hC: begin d.kind = K_CALL; d.len = nib_len; end
      4'hD: d.kind = K_RET;
      4'hE: begin d.kind = K_DIV;  d.len = nib_len; end
      4'hF: begin
        case (op[3:0])
          4'h0: d.kind = K_HLT;
          4'h1: begin d.kind = K_MUL;  d.len = 2'd2; end
          4'h2: d.kind = K_NOT;
          4'h3: begin d.kind = K_CMP;  d.len = 2'd2; end
          4'h8: begin d.kind = K_JZL;  d.len = 2'd3; end
          4'h9: begin d.kind = K_JMPL; d.len = 2'd3; end
          4'hA: begin d.kind = K_JNZL; d.len = 2'd3; end
          default: d.kind = K_NOP;
        endcase
      end
      default: d.kind = K_NOP;
    endcase
    case (d.kind)
      K_LDA, K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_DIV, K_MUL, K_CMP: d.rd_mem = 1'b1;
      default: d.rd_mem = 1'b0;
    endcase
    return d;
  endfunction

  function automatic logic [DW-1:0] alu_calc(input kind_e k, input logic [DW-1:0] a,
                                             input logic [DW-1:0] m);
    logic [2*DW-1:0] prod;
    logic [DW-1:0]   r;
    prod = {{DW{1'b0}}, a} * {{DW{1'b0}}, m};
    case (k)
      K_LDA, K_LDI: r = m;
      K_ADD:        r = a + m;
      K_SUB, K_CMP: r = a - m;
      K_AND:        r = a & m;
      K_OR:         r = a | m;
      K_XOR:        r = a ^ m;
      K_MUL:        r = prod[DW-1:0];
      K_DIV:        r = (m == '0) ? {DW{1'b1}} : (a / m);
      K_NOT:        r = ~a;
      default:      r = a;
    endcase
    return r;
  endfunction

  function automatic logic writes_acc(input kind_e k);
    case (k)
      K_LDA, K_LDI, K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_MUL, K_DIV, K_NOT: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/acc_core_decode.sv
module acc_core_decode
  import acc_core_pkg::*;
(
  input  logic [DW-1:0] opcode,
  output dec_t          dec
);
  assign dec = decode_op(opcode);
endmodule

// File: rtl/acc_core_alu.sv
module acc_core_alu
  import acc_core_pkg::*;
(
  input  kind_e         kind,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] res,
  output logic          res_zero
);
  assign res      = alu_calc(kind, acc, opnd);
  assign res_zero = (res == '0);
endmodule

// File: rtl/acc_core_pcgen.sv
module acc_core_pcgen
  import acc_core_pkg::*;
(
  input  kind_e         kind,
  input  logic [AW-1:0] pc,
  input  logic [LW-1:0] len,
  input  logic [AW-1:0] opnd,
  input  logic          zf,
  input  logic [DW-1:0] ret_byte,
  output logic [AW-1:0] seq_pc,
  output logic [AW-1:0] nxt_pc,
  output logic          taken
);
  localparam int PADW = AW - DW;

  logic [AW-1:0] tgt;

  assign seq_pc = pc + {{(AW-LW){1'b0}}, len};

  always_comb begin
    taken = 1'b0;
    tgt   = {{PADW{1'b0}}, opnd[DW-1:0]};
    case (kind)
      K_JZ:   taken = zf;
      K_JNZ:  taken = !zf;
      K_JMP:  taken = 1'b1;
      K_CALL: taken = 1'b1;
      K_RET:  begin taken = 1'b1; tgt = {{PADW{1'b0}}, ret_byte}; end
      K_JZL:  begin taken = zf;   tgt = opnd; end
      K_JMPL: begin taken = 1'b1; tgt = opnd; end
      K_JNZL: begin taken = !zf;  tgt = opnd; end
      default: taken = 1'b0;
    endcase
  end

  assign nxt_pc = taken ? tgt : seq_pc;
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter logic [AW-1:0] PC_RESET = '0,
  parameter logic [DW-1:0] SP_RESET = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] sp_o,
  output logic          zf_o,
  output logic          halted_o
);
  localparam int PADW = AW - DW;

  state_e        state_q, state_d;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] acc_q, sp_q, ir_q, ptr_hi_q, mdata_q;
  logic [AW-1:0] opnd_q;
  logic          zf_q;

  // decode: straight from the bus in the opcode cycle, from ir afterwards
  logic [DW-1:0] dec_byte;
  dec_t          dec;
  assign dec_byte = (state_q == ST_OPC) ? mem_rdata : ir_q;

  acc_core_decode u_dec (.opcode(dec_byte), .dec(dec));

  logic [DW-1:0] alu_m, alu_res;
  logic          alu_zero;
  assign alu_m = (dec.kind == K_LDI) ? opnd_q[DW-1:0] : mdata_q;

  acc_core_alu u_alu (
    .kind(dec.kind), .acc(acc_q), .opnd(alu_m), .res(alu_res), .res_zero(alu_zero)
  );

  logic [AW-1:0] seq_pc, nxt_pc;
  logic          br_taken;

  acc_core_pcgen u_pcg (
    .kind(dec.kind), .pc(pc_q), .len(dec.len), .opnd(opnd_q), .zf(zf_q),
    .ret_byte(mdata_q), .seq_pc(seq_pc), .nxt_pc(nxt_pc), .taken(br_taken)
  );

  // named events for the checker
  logic exec_fire, push_fire, pop_fire, acc_wr, cmp_fire, halt_fire;
  assign exec_fire = (state_q == ST_EXEC);
  assign push_fire = exec_fire && (dec.kind == K_CALL);
  assign pop_fire  = exec_fire && (dec.kind == K_RET);
  assign acc_wr    = exec_fire && writes_acc(dec.kind);
  assign cmp_fire  = exec_fire && (dec.kind == K_CMP);
  assign halt_fire = exec_fire && (dec.kind == K_HLT);

  always_comb begin
    state_d   = state_q;
    mem_addr  = pc_q;
    mem_we    = 1'b0;
    mem_wdata = acc_q;
    case (state_q)
      ST_FETCH: begin
        mem_addr = pc_q;
        state_d  = ST_OPC;
      end
      ST_OPC: begin
        if (dec.len != 2'd1) begin
          mem_addr = pc_q + 16'd1;
          state_d  = ST_OPND1;
        end else begin
          state_d  = ST_DISP;
        end
      end
      ST_OPND1: begin
        if (dec.len == 2'd3) begin
          mem_addr = pc_q + 16'd2;
          state_d  = ST_OPND2;
        end else begin
          state_d  = ST_DISP;
        end
      end
      ST_OPND2: state_d = ST_DISP;
      ST_DISP: begin
        if (dec.kind == K_STI) begin
          mem_addr = {{PADW{1'b0}}, opnd_q[AW-1:DW]};
          state_d  = ST_PTRHI;
        end else if (dec.rd_mem) begin
          mem_addr = {{PADW{1'b0}}, opnd_q[DW-1:0]};
          state_d  = ST_MEMRD;
        end else if (dec.kind == K_RET) begin
          mem_addr = {{PADW{1'b0}}, sp_q};
          state_d  = ST_MEMRD;
        end else begin
          state_d  = ST_EXEC;
        end
      end
      ST_PTRHI: begin
        mem_addr = {{PADW{1'b0}}, opnd_q[DW-1:0]};
        state_d  = ST_PTRLO;
      end
      ST_PTRLO: state_d = ST_EXEC;
      ST_MEMRD: state_d = ST_EXEC;
      ST_EXEC: begin
        case (dec.kind)
          K_STA: begin
            mem_addr = {{PADW{1'b0}}, opnd_q[DW-1:0]};
            mem_we   = 1'b1;
          end
          K_STI: begin
            mem_addr = opnd_q;
            mem_we   = 1'b1;
          end
          K_CALL: begin
            mem_addr  = {{PADW{1'b0}}, sp_q - 8'd1};
            mem_wdata = seq_pc[DW-1:0];
            mem_we    = 1'b1;
          end
          default: mem_we = 1'b0;
        endcase
        state_d = (dec.kind == K_HLT) ? ST_HALT : ST_FETCH;
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_FETCH;
      pc_q     <= PC_RESET;
      acc_q    <= '0;
      sp_q     <= SP_RESET;
      zf_q     <= 1'b0;
      ir_q     <= '0;
      opnd_q   <= '0;
      ptr_hi_q <= '0;
      mdata_q  <= '0;
    end else begin
      state_q <= state_d;
      case (state_q)
        ST_OPC: begin
          ir_q   <= mem_rdata;
          opnd_q <= {{(AW-4){1'b0}}, mem_rdata[3:0]};
        end
        ST_OPND1: opnd_q   <= {{PADW{1'b0}}, mem_rdata};
        ST_OPND2: opnd_q   <= {opnd_q[DW-1:0], mem_rdata};
        ST_PTRHI: ptr_hi_q <= mem_rdata;
        ST_PTRLO: opnd_q   <= {ptr_hi_q, mem_rdata};
        ST_MEMRD: mdata_q  <= mem_rdata;
        ST_EXEC: begin
          if (acc_wr) begin
            acc_q <= alu_res;
            zf_q  <= alu_zero;
          end
          if (cmp_fire)  zf_q <= alu_zero;
          if (push_fire) sp_q <= sp_q - 8'd1;
          if (pop_fire)  sp_q <= sp_q + 8'd1;
          if (!halt_fire) pc_q <= nxt_pc;
        end
        default: ;
      endcase
    end
  end

  assign pc_o     = pc_q;
  assign acc_o    = acc_q;
  assign sp_o     = sp_q;
  assign zf_o     = zf_q;
  assign halted_o = (state_q == ST_HALT);

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] pc_o,
  input logic [7:0]  acc_o,
  input logic [7:0]  sp_o,
  input logic        zf_o,
  input logic        halted_o,
  input logic        mem_we,
  input logic        exec_fire,
  input logic        push_fire,
  input logic        pop_fire,
  input logic        acc_wr,
  input logic        cmp_fire
);
  // R12
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> (halted_o && $stable(pc_o)));

  // R12
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |-> !mem_we);

  // R7
  we_in_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> exec_fire);

  // R11
  push_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |-> mem_we);

  // R11
  push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> (sp_o == ($past(sp_o) - 8'd1)));

  // R11
  pop_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> (sp_o == ($past(sp_o) + 8'd1)));

  // R6
  cmp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> $stable(acc_o));

  // R6
  zf_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> (zf_o == (acc_o == 8'h00)));
endmodule

bind acc_core acc_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pc_o(pc_o), .acc_o(acc_o), .sp_o(sp_o), .zf_o(zf_o),
  .halted_o(halted_o), .mem_we(mem_we), .exec_fire(exec_fire), .push_fire(push_fire),
  .pop_fire(pop_fire), .acc_wr(acc_wr), .cmp_fire(cmp_fire)
);

// File: tb/acc_core_bench.sv
module acc_core_bench;
  localparam int MW = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we;
  logic [15:0] pc_o;
  logic [7:0]  acc_o, sp_o;
  logic        zf_o, halted_o;

  logic          clr = 1'b0, ld_en = 1'b0;
  logic [MW-1:0] ld_a = '0;
  logic [7:0]    ld_d = '0;
  logic [7:0]    mem [2**MW];

  int total = 0;
  int bad = 0;

  logic [15:0] exp_a[$];
  logic [7:0]  exp_d[$];
  string       exp_t[$];

  always #5 clk = ~clk;

  acc_core u_acc_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .pc_o(pc_o), .acc_o(acc_o),
    .sp_o(sp_o), .zf_o(zf_o), .halted_o(halted_o)
  );

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 2**MW; i++) mem[i] <= 8'h00;
    end else begin
      if (ld_en)  mem[ld_a] <= ld_d;
      if (mem_we) mem[mem_addr[MW-1:0]] <= mem_wdata;
    end
    mem_rdata <= mem[mem_addr[MW-1:0]];
  end

  // monitor: each write pops one expected item
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      total++;
      if (exp_a.size() == 0) begin
        bad++;
        $display("FAIL R7 unexpected write act=%h/%h exp=none", mem_addr, mem_wdata);
      end else begin
        logic [15:0] ea;
        logic [7:0]  ed;
        string       et;
        ea = exp_a.pop_front();
        ed = exp_d.pop_front();
        et = exp_t.pop_front();
        if (mem_addr !== ea || mem_wdata !== ed) begin
          bad++;
          $display("FAIL %s write act=%h/%h exp=%h/%h", et, mem_addr, mem_wdata, ea, ed);
        end
      end
    end
  end

  task automatic expect_wr(input logic [15:0] a, input logic [7:0] d, input string t);
    exp_a.push_back(a);
    exp_d.push_back(d);
    exp_t.push_back(t);
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic lb(input logic [MW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_a = a; ld_d = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic begin_prog();
    @(negedge clk);
    rst_n = 1'b0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic run_prog(input int limit);
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < limit && !halted_o; c++) @(negedge clk);
    chk("R12 halted", {31'd0, halted_o}, 32'd1);
    total++;
    if (exp_a.size() != 0) begin
      bad++;
      $display("FAIL R7 missing writes act=%0d exp=0", exp_a.size());
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R12 watchdog act=running exp=halted");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // ---------- program 1: ALU chain ----------
    begin_prog();
    lb(10'h000, 8'hB0); lb(10'h001, 8'h20);
    lb(10'h020, 8'hA0); lb(10'h021, 8'h07);
    lb(10'h022, 8'h2A);
    lb(10'h023, 8'hA0); lb(10'h024, 8'h05);
    lb(10'h025, 8'h3A);
    lb(10'h026, 8'h21); lb(10'h027, 8'h70);
    lb(10'h028, 8'h40); lb(10'h029, 8'h61);
    lb(10'h02A, 8'h50); lb(10'h02B, 8'h64);
    lb(10'h02C, 8'h60); lb(10'h02D, 8'h62);
    lb(10'h02E, 8'h70); lb(10'h02F, 8'h63);
    lb(10'h030, 8'h21); lb(10'h031, 8'h77);
    lb(10'h032, 8'hF1); lb(10'h033, 8'h64);
    lb(10'h034, 8'hF2);
    lb(10'h035, 8'hE0); lb(10'h036, 8'h64);
    lb(10'h037, 8'h21); lb(10'h038, 8'h78);
    lb(10'h039, 8'hE0); lb(10'h03A, 8'h65);
    lb(10'h03B, 8'h21); lb(10'h03C, 8'h79);
    lb(10'h03D, 8'h10); lb(10'h03E, 8'h66);
    lb(10'h03F, 8'hF3); lb(10'h040, 8'h66);
    lb(10'h041, 8'h21); lb(10'h042, 8'h7A);
    lb(10'h043, 8'hF0);
    lb(10'h061, 8'h06); lb(10'h062, 8'hF0); lb(10'h063, 8'h0F);
    lb(10'h064, 8'h03); lb(10'h065, 8'h00); lb(10'h066, 8'h30);
    expect_wr(16'h000A, 8'h07, "R3 nibble store");
    expect_wr(16'h0070, 8'h0C, "R4 add");
    expect_wr(16'h0077, 8'hFD, "R4 sub/and/or/xor");
    expect_wr(16'h0078, 8'h02, "R5 div");
    expect_wr(16'h0079, 8'hFF, "R5 div by zero");
    expect_wr(16'h007A, 8'h30, "R6 cmp keeps acc");
    // R1 reset state
    @(negedge clk);
    chk("R1 pc", {16'd0, pc_o}, 32'h0000);
    chk("R1 sp", {24'd0, sp_o}, 32'hFF);
    chk("R1 acc", {24'd0, acc_o}, 32'h00);
    chk("R1 zf", {31'd0, zf_o}, 32'd0);
    chk("R1 halted", {31'd0, halted_o}, 32'd0);
    run_prog(3000);
    chk("R2 pc at halt", {16'd0, pc_o}, 32'h0043);
    chk("R6 acc after cmp", {24'd0, acc_o}, 32'h30);
    chk("R6 zf from cmp", {31'd0, zf_o}, 32'd1);
    chk("R11 sp untouched", {24'd0, sp_o}, 32'hFF);
    repeat (20) @(negedge clk);
    chk("R12 pc holds", {16'd0, pc_o}, 32'h0043);
    chk("R12 still halted", {31'd0, halted_o}, 32'd1);

    // ---------- program 2: branches ----------
    begin_prog();
    lb(10'h000, 8'hA0); lb(10'h001, 8'h03);
    lb(10'h002, 8'h4E);
    lb(10'h003, 8'h2F);
    lb(10'h004, 8'h92);
    lb(10'h005, 8'h87);
    lb(10'h006, 8'hF0);
    lb(10'h007, 8'h1F);
    lb(10'h008, 8'hB0); lb(10'h009, 8'h20);
    lb(10'h00E, 8'h01);
    lb(10'h020, 8'h90); lb(10'h021, 8'h30);
    lb(10'h022, 8'hA0); lb(10'h023, 8'h01);
    lb(10'h024, 8'h80); lb(10'h025, 8'h30);
    lb(10'h026, 8'h2D);
    lb(10'h027, 8'hF0);
    expect_wr(16'h000F, 8'h02, "R9 loop pass 1");
    expect_wr(16'h000F, 8'h01, "R9 loop pass 2");
    expect_wr(16'h000F, 8'h00, "R6 sub to zero");
    expect_wr(16'h000D, 8'h01, "R9 untaken branches");
    run_prog(3000);
    chk("R9 pc at halt", {16'd0, pc_o}, 32'h0027);
    chk("R4 acc", {24'd0, acc_o}, 32'h01);
    chk("R6 zf clear", {31'd0, zf_o}, 32'd0);

    // ---------- program 3: call, indirect, long jumps ----------
    begin_prog();
    lb(10'h000, 8'hA0); lb(10'h001, 8'h2A);
    lb(10'h002, 8'hC8);
    lb(10'h003, 8'hF9); lb(10'h004, 8'h02); lb(10'h005, 8'h00);
    lb(10'h006, 8'hF0);
    lb(10'h008, 8'h20); lb(10'h009, 8'h50); lb(10'h00A, 8'h51);
    lb(10'h00B, 8'hD0);
    lb(10'h050, 8'h03); lb(10'h051, 8'h05);
    lb(10'h200, 8'hA0); lb(10'h201, 8'h00);
    lb(10'h202, 8'hF8); lb(10'h203, 8'h03); lb(10'h204, 8'h10);
    lb(10'h205, 8'hF0);
    lb(10'h310, 8'hFA); lb(10'h311, 8'h02); lb(10'h312, 8'h00);
    lb(10'h313, 8'hA0); lb(10'h314, 8'h09);
    lb(10'h315, 8'hFA); lb(10'h316, 8'h03); lb(10'h317, 8'h20);
    lb(10'h318, 8'hF0);
    lb(10'h320, 8'h21); lb(10'h321, 8'h60);
    lb(10'h322, 8'hF8); lb(10'h323, 8'h00); lb(10'h324, 8'h06);
    lb(10'h325, 8'hF0);
    expect_wr(16'h00FE, 8'h03, "R11 call push");
    expect_wr(16'h0305, 8'h2A, "R8 indirect store");
    expect_wr(16'h0060, 8'h09, "R10 long jumps");
    run_prog(3000);
    chk("R10 pc at halt", {16'd0, pc_o}, 32'h0325);
    chk("R11 sp restored", {24'd0, sp_o}, 32'hFF);
    chk("R4 acc", {24'd0, acc_o}, 32'h09);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule